// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Write Sequencer

This block writes one 16-bit word into an EEPROM-style configuration port that listens on three wires: a chip select, a serial clock and a serial data line driven by the block. One pulse on the start input latches an address, a data word and a clock half-period setting. The block then runs three framed transactions back to back without further help. The first frame unlocks the port for writing. The second frame carries the write opcode, the address and the data. The third frame locks the port again.

Every frame has the same shape. The lines first sit idle for one half-period. Chip select then rises and stays high for one more half-period before any clock. The serial bits follow, each one a full low-then-high clock cycle. Chip select then drops, the block waits one half-period, and gives a single extra clock pulse while chip select is low. The internal clock counts `half_div_i + 1` system cycles per half-period. A done pulse reports that the locking frame has finished. The block has no read path and does not poll the port for busy.

Top module: `mw_wr_seq`

## Requirements
- R1: While reset is held, and while idle, cs_o is 0, sk_o is 0, do_o is 1 and done_o is 0.
- R2: A start accepted while idle produces exactly three chip-select frames in this order: write-enable, write, write-disable.
- R3: Each frame starts with one idle half-period (cs_o 0, sk_o 0, do_o 1). cs_o then rises with sk_o low and do_o high, and the first serial clock rises no earlier than one half-period later.
- R4: The enable frame shifts the 5-bit pattern 1,0,0,1,1 and the disable frame shifts 1,0,0,0,0. Each is followed by ADDR_W-2 zero bits, so both frames are ADDR_W+3 bits long.
- R5: The write frame shifts a start bit 1, the opcode bits 0,1, the ADDR_W address bits and then the DATA_W data bits. Every field goes out most significant bit first, so the frame is 3+ADDR_W+DATA_W bits long.
- R6: do_o changes only while sk_o is low, and each sk_o high phase lasts exactly half_div_i+1 system clock cycles, using the value latched at start.
- R7: After the last bit of a frame, cs_o falls with sk_o low. One half-period later exactly one trailing sk_o pulse is given while cs_o stays low, so each command carries three trailing pulses.
- R8: done_o is high for exactly one cycle per command. It rises on the clock edge that lies 2*(3*ADDR_W+DATA_W+9)+15 half-periods after the edge that accepts start, which is 113 half-periods for the defaults. No pins move after done until the next start.
- R9: A start pulse, or new address and data, that arrives while a command is in progress is ignored. The frames still carry the latched values, and only one done pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command strobe, honoured only when idle |
| addr_i | input | ADDR_W | Target word address |
| data_i | input | DATA_W | Word to write |
| half_div_i | input | DIV_W | Serial clock half-period minus one, in system cycles |
| cs_o | output | 1 | Chip select to the port, active high |
| sk_o | output | 1 | Serial clock to the port |
| do_o | output | 1 | Serial data to the port |
| done_o | output | 1 | One-cycle pulse when the disable frame has finished |

## Verification
The accepting edge moves the block out of idle, and every later phase change falls on a tick that comes half_div_i+1 cycles after the previous one. done_o is therefore due on the negative edge that follows posedge number 113*(half_div_i+1)+1, counting the accepting edge as 1. The bench counts negative edges from the strobe to check exactly that figure. A monitor samples the pins on every negative edge. It takes a serial bit only at a sampled low-to-high step of sk_o while cs_o is high, and it measures sk_o high phases in samples. In this way bit content, half-period length and trailing pulses are judged at the points where they settle, never at the driving edge.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_CSUP,
    PH_BLO,
    PH_BHI,
    PH_CSDN,
    PH_THI,
    PH_TLO
  } mw_phase_e;

  typedef enum logic [1:0] {
    FR_WEN,
    FR_WR,
    FR_WDS
  } mw_frame_e;

  localparam logic [3:0] WEN_CODE = 4'b0011;
  localparam logic [3:0] WDS_CODE = 4'b0000;
  localparam logic [1:0] WR_OP    = 2'b01;

endpackage

// File: rtl/mw_rst_sync.sv
module mw_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = run_i && wrap;

  always_comb begin
    if (!run_i)    cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mw_frame_fmt.sv
module mw_frame_fmt
  import mw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 3 + ADDR_W + DATA_W,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  mw_frame_e           frame_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [FRAME_W-1:0]  bits_o,
  output logic [LEN_W-1:0]    len_o
);

  localparam int SHORT_LEN = ADDR_W + 3;

  always_comb begin
    bits_o = '0;
    len_o  = LEN_W'(SHORT_LEN);
    case (frame_i)
      FR_WR: begin
        bits_o = {1'b1, WR_OP, addr_i, data_i};
        len_o  = LEN_W'(FRAME_W);
      end
      FR_WEN: bits_o[FRAME_W-1 -: 5] = {1'b1, WEN_CODE};
      default: bits_o[FRAME_W-1 -: 5] = {1'b1, WDS_CODE};
    endcase
  end

endmodule

// File: rtl/mw_seq_ctl.sv
module mw_seq_ctl
  import mw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 8,
  parameter int FRAME_W = 3 + ADDR_W + DATA_W,
  parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               start_i,
  input  logic               tick_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [FRAME_W-1:0] fr_bits_i,
  input  logic [LEN_W-1:0]   fr_len_i,
  output logic               run_o,
  output mw_frame_e          frame_o,
  output logic [ADDR_W-1:0]  addr_q_o,
  output logic [DATA_W-1:0]  data_q_o,
  output logic [DIV_W-1:0]   div_q_o,
  output logic               cs_o,
  output logic               sk_o,
  output logic               do_o,
  output logic               done_o
);

  mw_phase_e          ph_q, ph_d;
  mw_frame_e          fr_q, fr_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic               done_q, done_d;
  logic               load_en;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [DIV_W-1:0]   div_q;

  // next-state logic: idle accepts a command, every other phase waits for a tick
  always_comb begin
    ph_d    = ph_q;
    fr_d    = fr_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load_en = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_d    = PH_PRE;
        fr_d    = FR_WEN;
        load_en = 1'b1;
      end
    end else if (tick_i) begin
      case (ph_q)
        PH_PRE:  ph_d = PH_CSUP;
        PH_CSUP: begin
          ph_d  = PH_BLO;
          sh_d  = fr_bits_i;
          cnt_d = fr_len_i;
        end
        PH_BLO:  ph_d = PH_BHI;
        PH_BHI: begin
          if (cnt_q == LEN_W'(1)) begin
            ph_d = PH_CSDN;
          end else begin
            ph_d  = PH_BLO;
            sh_d  = sh_q << 1;
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_CSDN: ph_d = PH_THI;
        PH_THI:  ph_d = PH_TLO;
        PH_TLO: begin
          if (fr_q == FR_WDS) begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end else begin
            ph_d = PH_PRE;
            fr_d = (fr_q == FR_WEN) ? FR_WR : FR_WDS;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ph_q   <= PH_IDLE;
      fr_q   <= FR_WEN;
      sh_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      fr_q   <= fr_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q <= '0;
      data_q <= '0;
      div_q  <= '0;
    end else if (load_en) begin
      addr_q <= addr_i;
      data_q <= data_i;
      div_q  <= div_i;
    end
  end

  // pin decode from the registered phase
  always_comb begin
    cs_o = 1'b0;
    sk_o = 1'b0;
    do_o = 1'b0;
    case (ph_q)
      PH_IDLE, PH_PRE: do_o = 1'b1;
      PH_CSUP: begin
        cs_o = 1'b1;
        do_o = 1'b1;
      end
      PH_BLO: begin
        cs_o = 1'b1;
        do_o = sh_q[FRAME_W-1];
      end
      PH_BHI: begin
        cs_o = 1'b1;
        sk_o = 1'b1;
        do_o = sh_q[FRAME_W-1];
      end
      PH_THI:  sk_o = 1'b1;
      default: ;
    endcase
  end

  assign run_o    = (ph_q != PH_IDLE);
  assign frame_o  = fr_q;
  assign addr_q_o = addr_q;
  assign data_q_o = data_q;
  assign div_q_o  = div_q;
  assign done_o   = done_q;

endmodule

// File: rtl/mw_wr_seq.sv
module mw_wr_seq
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DIV_W-1:0]  half_div_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              do_o,
  output logic              done_o
);

  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic               rst_n_s;
  logic               run;
  logic               tick;
  mw_frame_e          frame;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [DIV_W-1:0]   div_q;
  logic [FRAME_W-1:0] fr_bits;
  logic [LEN_W-1:0]   fr_len;

  mw_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_s)
  );

  mw_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_s),
    .run_i   (run),
    .div_i   (div_q),
    .tick_o  (tick)
  );

  mw_frame_fmt #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .LEN_W   (LEN_W)
  ) u_fmt (
    .frame_i (frame),
    .addr_i  (addr_q),
    .data_i  (data_q),
    .bits_o  (fr_bits),
    .len_o   (fr_len)
  );

  mw_seq_ctl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DIV_W   (DIV_W),
    .FRAME_W (FRAME_W),
    .LEN_W   (LEN_W)
  ) u_ctl (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_s),
    .start_i   (start_i),
    .tick_i    (tick),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .div_i     (half_div_i),
    .fr_bits_i (fr_bits),
    .fr_len_i  (fr_len),
    .run_o     (run),
    .frame_o   (frame),
    .addr_q_o  (addr_q),
    .data_q_o  (data_q),
    .div_q_o   (div_q),
    .cs_o      (cs_o),
    .sk_o      (sk_o),
    .do_o      (do_o),
    .done_o    (done_o)
  );

endmodule

// File: rtl/mw_wr_seq_chk.sv
module mw_wr_seq_chk (
  input logic clk_i,
  input logic rst_n_i,
  input logic cs_o,
  input logic sk_o,
  input logic do_o,
  input logic done_o
);

  // R6: data holds its value while the serial clock is high
  a_r6_data_stable_high: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sk_o |-> $stable(do_o));

  // R3: chip select rises with the clock low and data high
  a_r3_cs_rise_clean: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(cs_o) |-> (!sk_o && do_o));

  // R7: chip select falls with the clock low
  a_r7_cs_fall_clk_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(cs_o) |-> !sk_o);

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> !done_o);

  // R1: lines are in the idle state when done is reported
  a_r1_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> (!cs_o && !sk_o && do_o));

endmodule

bind mw_wr_seq mw_wr_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_n_i (rst_n_i),
  .cs_o    (cs_o),
  .sk_o    (sk_o),
  .do_o    (do_o),
  .done_o  (done_o)
);

// File: tb/mw_wr_seq_bench.sv
`timescale 1ns/1ps
module mw_wr_seq_bench;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 8;
  localparam int SHORT_LEN = ADDR_W + 3;
  localparam int LONG_LEN  = 3 + ADDR_W + DATA_W;
  localparam int HALVES    = 2 * (2 * SHORT_LEN + LONG_LEN) + 15;
  localparam int NVEC = 4;
  localparam int VW   = ADDR_W + DATA_W + DIV_W;
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {8'hA5, 16'h3C5A, 8'd1},
    {8'h00, 16'hFFFF, 8'd0},
    {8'hFF, 16'h0000, 8'd2},
    {8'h5A, 16'h8001, 8'd3}
  };

  logic              clk_i;
  logic              rst_n_i;
  logic              start_i;
  logic [ADDR_W-1:0] addr_i;
  logic [DATA_W-1:0] data_i;
  logic [DIV_W-1:0]  half_div_i;
  logic              cs_o, sk_o, do_o, done_o;

  int n_cmp;
  int n_bad;

  mw_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) u_mw_wr_seq (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .half_div_i (half_div_i),
    .cs_o       (cs_o),
    .sk_o       (sk_o),
    .do_o       (do_o),
    .done_o     (done_o)
  );

  initial clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // pin monitor, sampled on negative edges
  logic [63:0] fr_bits [3];
  int          fr_len  [3];
  int          fr_n, trail_n, hi_min, hi_max, hi_run, done_n;
  logic [63:0] cur;
  int          cur_len;
  logic        psk, pcs;

  task automatic clear_mon();
    for (int k = 0; k < 3; k++) begin
      fr_bits[k] = '0;
      fr_len[k]  = 0;
    end
    fr_n = 0; trail_n = 0; hi_min = 1 << 30; hi_max = 0; hi_run = 0;
    done_n = 0; cur = '0; cur_len = 0;
  endtask

  always @(negedge clk_i) begin
    if (sk_o && !psk) begin
      if (cs_o) begin
        cur = {cur[62:0], do_o};
        cur_len++;
      end else begin
        trail_n++;
      end
    end
    if (sk_o) begin
      hi_run++;
    end else if (psk) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    if (!cs_o && pcs) begin
      if (fr_n < 3) begin
        fr_bits[fr_n] = cur;
        fr_len[fr_n]  = cur_len;
      end
      fr_n++;
      cur = '0;
      cur_len = 0;
    end
    if (done_o) done_n++;
    psk = sk_o;
    pcs = cs_o;
  end

  task automatic run_cmd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input logic [DIV_W-1:0] dv, input bit inject);
    int          lat;
    logic [63:0] e_en, e_wr, e_ds;
    e_en = 64'(5'b10011) << (ADDR_W - 2);
    e_ds = 64'(5'b10000) << (ADDR_W - 2);
    e_wr = 64'({3'b101, a, d});
    @(negedge clk_i);
    addr_i = a; data_i = d; half_div_i = dv; start_i = 1'b1;
    clear_mon();
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 5000) begin
      if (inject && lat == 40) begin
        start_i = 1'b1; addr_i = ~a; data_i = ~d; half_div_i = dv + 1'b1;
      end
      if (inject && lat == 41) start_i = 1'b0;
      @(negedge clk_i);
      lat++;
    end
    chk(lat == HALVES * (int'(dv) + 1) + 1, "R8", "done latency", lat,
        HALVES * (int'(dv) + 1) + 1);
    repeat (4 * (int'(dv) + 1) + 4) @(negedge clk_i);
    chk(fr_n == 3, "R2", "frame count", fr_n, 3);
    chk(fr_bits[0] == e_en && fr_len[0] == SHORT_LEN, "R4", "enable frame", fr_bits[0], e_en);
    chk(fr_bits[1] == e_wr && fr_len[1] == LONG_LEN, "R5", "write frame", fr_bits[1], e_wr);
    chk(fr_bits[2] == e_ds && fr_len[2] == SHORT_LEN, "R4", "disable frame", fr_bits[2], e_ds);
    chk(hi_min == int'(dv) + 1 && hi_max == int'(dv) + 1, "R6", "clock high width",
        hi_max, int'(dv) + 1);
    chk(trail_n == 3, "R7", "trailing pulses", trail_n, 3);
    chk(done_n == 1, inject ? "R9" : "R8", "done pulses", done_n, 1);
    chk(!cs_o && !sk_o && do_o, "R1", "idle after command", {cs_o, sk_o, do_o}, 3'b001);
  endtask

  bit wd_hit;
  initial begin
    wd_hit = 1'b0;
    #(200000 * 5);
    wd_hit = 1'b1;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    psk = 1'b0; pcs = 1'b0;
    clear_mon();
    rst_n_i = 1'b0; start_i = 1'b0; addr_i = '0; data_i = '0; half_div_i = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(!cs_o && !sk_o && do_o && !done_o, "R1", "pins in reset",
        {cs_o, sk_o, do_o, done_o}, 4'b0010);
    rst_n_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(!cs_o && !sk_o && do_o && !done_o, "R1", "pins idle after reset",
        {cs_o, sk_o, do_o, done_o}, 4'b0010);

    // stimulus table
    for (int i = 0; i < NVEC; i++) begin
      run_cmd(VEC[i][VW-1 -: ADDR_W], VEC[i][DATA_W+DIV_W-1 -: DATA_W],
              VEC[i][DIV_W-1:0], 1'b0);
    end

    // R3: setup half-period before chip select, then before the first clock
    @(negedge clk_i);
    addr_i = 8'h3C; data_i = 16'h1234; half_div_i = 8'd2; start_i = 1'b1;
    clear_mon();
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(!cs_o && !sk_o && do_o, "R3", "pre phase lines", {cs_o, sk_o, do_o}, 3'b001);
    @(negedge clk_i);
    chk(cs_o && !sk_o && do_o, "R3", "cs up, clock low", {cs_o, sk_o, do_o}, 3'b101);
    repeat (2) @(negedge clk_i);
    chk(cs_o && !sk_o, "R3", "no clock during cs setup", {cs_o, sk_o}, 2'b10);
    while (!done_o) @(negedge clk_i);
    repeat (8) @(negedge clk_i);

    // R9: strobe and new inputs during a command are ignored
    run_cmd(8'hC3, 16'hBEEF, 8'd1, 1'b1);
    repeat (20) @(negedge clk_i);
    chk(!cs_o && !sk_o && fr_n == 3, "R9", "no extra command", fr_n, 3);

    if (!wd_hit) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule